// File: doc/BRIEF.md
# Break-match trigger pulse generator

This block sits beside the comparison logic of a debug break unit. Each time that logic reports a break-condition match with a one-cycle strobe, the block drives an active-high trigger output for a set number of internal clock cycles. The same strobe also raises a break interrupt request, unless a disable flag in the control register blocks it. The request is a level that stays high until an acknowledge input clears it.

The block holds one 16-bit control register. Only its three low bits are implemented: a two-bit pulse-width code and the interrupt disable flag. Software reaches the register through a single-cycle write strobe and a read data port that is always valid. The pulse length for code 0 also depends on a static strap that gives the internal clock multiplication ratio.

Power-on reset clears the register, and so does module standby. Software standby keeps the register contents and blocks writes.

Top module: `brk_trig_unit`

## Requirements
- R1: After power-on reset (`rst_n` low at a clock edge), `reg_rdata` reads 0x0000, `trig_out` is 0 and `brk_irq` is 0.
- R2: Only bits 2:0 of the register are implemented. A write of 0xFFFF reads back as 0x0007, and bits 15:3 always read as zero.
- R3: Bits 2:1 hold the width code. Code 1 gives a trigger pulse of 4 cycles, code 2 gives 8 cycles and code 3 gives 16 cycles.
- R4: Code 0 gives a 2-cycle pulse when `mult_x8` is 0 (x4 ratio) and a 4-cycle pulse when `mult_x8` is 1 (x8 ratio).
- R5: `trig_out` rises on the clock edge that samples `match_stb` high while no pulse is running. A strobe that arrives while `trig_out` is high, including the last high cycle, neither restarts the pulse nor lengthens it.
- R6: The width code is captured when a pulse starts. A register write during the pulse does not change that pulse's length.
- R7: When bit 0 is 0, a match sets `brk_irq` on the next edge. `brk_irq` then stays high until an edge samples `irq_ack` high with no match in the same cycle. If a match and an acknowledge arrive in the same cycle, `brk_irq` stays set.
- R8: When bit 0 is 1, a match raises no interrupt request, but the trigger pulse is still produced.
- R9: While `mod_stby` is high, the register is cleared, `reg_rdata` reads zero, any pulse in progress ends, `brk_irq` is cleared, and matches produce neither a pulse nor a request.
- R10: While `sw_stby` is high, writes are ignored and the register keeps its value. The value can still be read during and after software standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| mod_stby | input | 1 | Module standby; clears and silences the block |
| sw_stby | input | 1 | Software standby; freezes the register |
| mult_x8 | input | 1 | Static strap: 1 = x8 clock ratio, 0 = x4 |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| match_stb | input | 1 | Break-condition match strobe |
| irq_ack | input | 1 | Interrupt request acknowledge |
| trig_out | output | 1 | Active-high trigger pulse |
| brk_irq | output | 1 | Break interrupt request level |

## Verification
The bench builds the block with its default `MAX_LOG2` of 4, so the width codes give pulses of 2, 4, 8 and 16 cycles. Both strap settings are applied, which exercises every entry of the width table, including the ratio-dependent code 0. With these values the longest pulse is short enough that random stimulus can land strobes in every phase of a pulse, including its final cycle, along with writes in the middle of a pulse and overlaps of acknowledge and match.

// File: rtl/brk_trig_pkg.sv
// Shared constants and the width-code decode for the break trigger unit.
// Assumes the widest code (3) selects 2**max_log2 cycles and each lower
// code halves it; code 0 follows the clock-ratio strap.
package brk_trig_pkg;

    localparam int REG_W  = 16;
    localparam int CODE_W = 2;

    // Exponent of the pulse length for a width code and ratio strap.
    function automatic int pulse_exp(input int max_log2,
                                     input logic [CODE_W-1:0] code,
                                     input logic x8);
        int base;
        base = max_log2 - 3;
        if (code == '0)
            return base + (x8 ? 1 : 0);
        return base + int'(code);
    endfunction

endpackage

// File: rtl/brk_ctl_reg.sv
// Control register: width code in bits 2:1, interrupt disable in bit 0.
// Assumes a single-cycle write strobe; reserved bits are not stored.
// Power-on reset and module standby clear it; software standby freezes it.
module brk_ctl_reg
    import brk_trig_pkg::*;
#(
    parameter int DATA_W = REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mod_stby,
    input  logic              sw_stby,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [CODE_W-1:0] width_code,
    output logic              irq_dis,
    output logic [DATA_W-1:0] rdata
);

    localparam int IMPL_W = CODE_W + 1;

    logic [CODE_W-1:0] code_q;
    logic              dis_q;

    // Register update: clear on reset or module standby, write when awake.
    always_ff @(posedge clk) begin
        if (!rst_n || mod_stby) begin
            code_q <= '0;
            dis_q  <= 1'b0;
        end else if (wr_en && !sw_stby) begin
            code_q <= wdata[IMPL_W-1:1];
            dis_q  <= wdata[0];
        end
    end

    // Read view: implemented bits only, all zero in module standby.
    always_comb begin
        rdata = '0;
        if (!mod_stby)
            rdata[IMPL_W-1:0] = {code_q, dis_q};
    end

    assign width_code = code_q;
    assign irq_dis    = dis_q;

endmodule

// File: rtl/brk_pulse_gen.sv
// Trigger pulse generator: starts on a match while idle, holds the output
// high for the decoded number of cycles, and ignores matches meanwhile.
// Assumes the width code is stable in the cycle of the starting match.
module brk_pulse_gen
    import brk_trig_pkg::*;
#(
    parameter int MAX_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mod_stby,
    input  logic              match,
    input  logic [CODE_W-1:0] width_code,
    input  logic              mult_x8,
    output logic              trig
);

    localparam int CNT_W = MAX_LOG2;

    logic [CNT_W-1:0] remain_q;
    logic [CNT_W-1:0] load_val;
    logic             trig_q;

    // Decode the code into the count of cycles left after the first.
    always_comb begin
        int e;
        e        = pulse_exp(MAX_LOG2, width_code, mult_x8);
        load_val = CNT_W'((1 << e) - 1);
    end

    // Pulse sequencer: load on an idle match, count down, drop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n || mod_stby) begin
            trig_q   <= 1'b0;
            remain_q <= '0;
        end else if (!trig_q) begin
            if (match) begin
                trig_q   <= 1'b1;
                remain_q <= load_val;
            end
        end else if (remain_q == '0) begin
            trig_q <= 1'b0;
        end else begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign trig = trig_q;

endmodule

// File: rtl/brk_irq_gate.sv
// Break interrupt request: a level set by an enabled match and held until
// acknowledged. A match in the same cycle as an acknowledge keeps it set.
module brk_irq_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic mod_stby,
    input  logic match,
    input  logic irq_dis,
    input  logic ack,
    output logic irq
);

    logic irq_q;
    logic set_req;

    // A request is raised only when the disable flag is clear.
    assign set_req = match && !irq_dis;

    // Request level: set wins over acknowledge; standby clears it.
    always_ff @(posedge clk) begin
        if (!rst_n || mod_stby)
            irq_q <= 1'b0;
        else if (set_req)
            irq_q <= 1'b1;
        else if (ack)
            irq_q <= 1'b0;
    end

    assign irq = irq_q;

endmodule

// File: rtl/brk_trig_unit.sv
// Top of the break trigger unit. It joins the control register, the pulse
// generator and the interrupt gate. Assumes match_stb comes from the
// break comparison logic in the same clock domain and mult_x8 is static.
module brk_trig_unit
    import brk_trig_pkg::*;
#(
    parameter int MAX_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mod_stby,
    input  logic             sw_stby,
    input  logic             mult_x8,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             match_stb,
    input  logic             irq_ack,
    output logic             trig_out,
    output logic             brk_irq
);

    logic [CODE_W-1:0] width_code;
    logic              irq_dis;

    brk_ctl_reg #(.DATA_W(REG_W)) ctl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mod_stby   (mod_stby),
        .sw_stby    (sw_stby),
        .wr_en      (reg_wr),
        .wdata      (reg_wdata),
        .width_code (width_code),
        .irq_dis    (irq_dis),
        .rdata      (reg_rdata)
    );

    brk_pulse_gen #(.MAX_LOG2(MAX_LOG2)) pulse_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mod_stby   (mod_stby),
        .match      (match_stb),
        .width_code (width_code),
        .mult_x8    (mult_x8),
        .trig       (trig_out)
    );

    brk_irq_gate irq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mod_stby (mod_stby),
        .match    (match_stb),
        .irq_dis  (irq_dis),
        .ack      (irq_ack),
        .irq      (brk_irq)
    );

endmodule

// File: rtl/brk_trig_chk.sv
// Checker for brk_trig_unit, bound to every instance of the top.
module brk_trig_chk #(
    parameter int MAX_LOG2 = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        mod_stby,
    input logic        sw_stby,
    input logic        match_stb,
    input logic        irq_ack,
    input logic [15:0] reg_rdata,
    input logic        trig_out,
    input logic        brk_irq
);

    localparam int MAX_LEN = 1 << MAX_LOG2;

    logic [7:0] run_len;

    // Count consecutive high cycles of the trigger output.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_len <= '0;
        else if (trig_out)
            run_len <= run_len + 1'b1;
        else
            run_len <= '0;
    end

    // R5
    trig_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_out) |-> $past(match_stb));

    // R3
    trig_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(run_len) <= MAX_LEN);

    // R9
    stby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mod_stby |=> (!trig_out && !brk_irq));

    // R7
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_irq && !irq_ack && !mod_stby) |=> brk_irq);

    // R8
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_irq) |-> ($past(match_stb) && !$past(reg_rdata[0])));

    // R10
    sw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_stby && !mod_stby) |=> (mod_stby || $stable(reg_rdata)));

endmodule

bind brk_trig_unit brk_trig_chk #(.MAX_LOG2(MAX_LOG2)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mod_stby  (mod_stby),
    .sw_stby   (sw_stby),
    .match_stb (match_stb),
    .irq_ack   (irq_ack),
    .reg_rdata (reg_rdata),
    .trig_out  (trig_out),
    .brk_irq   (brk_irq)
);

// File: tb/brk_trig_unit_tb_top.sv
module brk_trig_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mod_stby = 1'b0;
    logic        sw_stby = 1'b0;
    logic        mult_x8 = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        match_stb = 1'b0;
    logic        irq_ack = 1'b0;
    logic        trig_out;
    logic        brk_irq;

    int checks = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    brk_trig_unit dut_i (
        .clk(clk), .rst_n(rst_n), .mod_stby(mod_stby), .sw_stby(sw_stby),
        .mult_x8(mult_x8), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .match_stb(match_stb), .irq_ack(irq_ack),
        .trig_out(trig_out), .brk_irq(brk_irq)
    );

    // Expected pulse length from the width table in R3 and R4.
    function automatic int exp_len(input logic [1:0] code, input logic x8);
        case (code)
            2'd1:    return 4;
            2'd2:    return 8;
            2'd3:    return 16;
            default: return x8 ? 4 : 2;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock: inputs change at a falling edge, outputs are read at the next one.
    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] v);
        reg_wr = 1'b1;
        reg_wdata = v;
        step();
        reg_wr = 1'b0;
    endtask

    // Start a pulse and measure it. Strobes may be applied during the pulse,
    // and one register write may be made at high-cycle number wr_at.
    task automatic pulse_len(input bit noise, input int wr_at,
                             input logic [15:0] wv, output int n);
        match_stb = 1'b1;
        step();
        match_stb = 1'b0;
        n = 0;
        while (trig_out && n < 40) begin
            n++;
            match_stb = noise ? 1'($urandom) : 1'b0;
            reg_wr = (n == wr_at);
            reg_wdata = wv;
            step();
        end
        match_stb = 1'b0;
        reg_wr = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin : main
        int n;
        void'($urandom(32'h5eed_1234));
        step();
        step();
        // R1 reset state
        check("R1 rdata", int'(reg_rdata), 0);
        check("R1 trig", int'(trig_out), 0);
        check("R1 irq", int'(brk_irq), 0);
        rst_n = 1'b1;
        step();

        // R2 reserved bits
        wr(16'hFFFF);
        check("R2 rdata", int'(reg_rdata), 16'h0007);

        // R3 / R4 every code with both straps; R8 pulse still produced while disabled
        for (int x = 0; x < 2; x++) begin
            mult_x8 = 1'(x);
            for (int c = 0; c < 4; c++) begin
                wr(16'(c << 1) | 16'h1);
                pulse_len(0, 0, 16'h0, n);
                check(c == 0 ? "R4 width" : "R3 width", n, exp_len(2'(c), 1'(x)));
                check("R8 no irq", int'(brk_irq), 0);
                step();
            end
        end

        // R5 the edge after the strobe is already high; strobes inside the pulse are ignored
        mult_x8 = 1'b0;
        wr(16'h0003);
        pulse_len(1, 0, 16'h0, n);
        check("R5 no retrigger", n, 4);
        step();
        check("R5 idle after", int'(trig_out), 0);

        // R6 write during a pulse does not change its length
        wr(16'h0007);
        pulse_len(0, 2, 16'h0003, n);
        check("R6 latched width", n, 16);
        pulse_len(0, 0, 16'h0, n);
        check("R6 new width next pulse", n, 4);
        step();

        // R7 interrupt set, hold, ack+match keeps it, ack alone clears it
        wr(16'h0002);
        match_stb = 1'b1; step(); match_stb = 1'b0;
        check("R7 irq set", int'(brk_irq), 1);
        repeat (20) step();
        check("R7 irq held", int'(brk_irq), 1);
        match_stb = 1'b1; irq_ack = 1'b1; step();
        match_stb = 1'b0;
        check("R7 set beats ack", int'(brk_irq), 1);
        step(); irq_ack = 1'b0;
        check("R7 ack clears", int'(brk_irq), 0);
        repeat (20) step();

        // R9 module standby
        wr(16'h0005);
        match_stb = 1'b1; step(); match_stb = 1'b0;
        mod_stby = 1'b1; step();
        check("R9 rdata zero", int'(reg_rdata), 0);
        check("R9 pulse ended", int'(trig_out), 0);
        check("R9 irq cleared", int'(brk_irq), 0);
        match_stb = 1'b1; step(); step(); match_stb = 1'b0;
        check("R9 no pulse", int'(trig_out), 0);
        check("R9 no irq", int'(brk_irq), 0);
        mod_stby = 1'b0; step();
        check("R9 cleared after", int'(reg_rdata), 0);

        // R10 software standby
        wr(16'h0004);
        sw_stby = 1'b1;
        wr(16'h0003);
        check("R10 write ignored", int'(reg_rdata), 16'h0004);
        sw_stby = 1'b0; step();
        check("R10 kept", int'(reg_rdata), 16'h0004);

        // Random mix of codes, straps and mid-pulse strobes (R3 R4 R5)
        for (int i = 0; i < 60; i++) begin
            logic [1:0] c;
            c = 2'($urandom);
            mult_x8 = 1'($urandom);
            wr({13'($urandom), c, 1'b1});
            check("R2 random rdata", int'(reg_rdata), int'({c, 1'b1}));
            pulse_len(1, 0, 16'h0, n);
            check("R3 random width", n, exp_len(c, mult_x8));
            step();
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule